// File: doc/BRIEF.md
# Page Table Walker (one level, flat table)

This block turns a virtual address into a physical address by reading one entry from a flat page table in physical memory. Software programs a base register with the physical address where the current table starts. Switching that register swaps the whole address space, so each process can own its own table. A walk starts when a request with a virtual address and an access kind (read, write or instruction fetch) arrives while the block is idle. The block forms the entry address by adding the virtual page number, scaled by the 4-byte entry size, to the base. It issues one read on a request/response memory port and decodes the returned entry.

The entry word carries a present flag in bit 31, a two-bit rights code in bits 30:29, reserved bits 28:22 and a 22-bit physical page number in bits 21:0. Pages are 1 KB. The low 10 address bits are the offset and pass through unchanged. The walk ends with a single-cycle completion pulse. With it comes either the translated physical address or a fault code, which tells software to handle the miss itself.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done` and `mem_req_valid` are low and the base register holds 0.
- R2: One cycle after a request is accepted, `mem_req_valid` is high with `mem_req_addr` = base + 4 × `req_vaddr[31:10]` (modulo 2^32). The request and its address hold steady until `mem_req_ready` is seen high.
- R3: A request is accepted only while `busy` is low. `req_valid` raised during a walk starts no further memory read and does not alter the walk in flight.
- R4: `busy` goes high the cycle after acceptance and stays high until the response is taken. `done` is high for exactly one cycle, the cycle after `mem_rsp_valid` is seen, and `busy` is low in that cycle.
- R5: An entry with bit 31 = 0 reports fault code 1 (not present) with `paddr` = 0, whatever its rights code.
- R6: For a present entry, rights 0 (read-only) permits access code 0 (read). Rights 1 (read/write) permits codes 0 and 1 (write). Rights 2 (execute) permits codes 0 and 2 (fetch). Rights 3 permits nothing, and access code 3 is never permitted. A refused access reports fault code 2 with `paddr` = 0.
- R7: A permitted access reports fault code 0 and `paddr` = {entry[21:0], `req_vaddr[9:0]`}. Entry bits 28:22 have no effect.
- R8: A base write with `busy` low takes effect for the next walk. A base write with `busy` high is dropped, and later walks still use the earlier base.
- R9: Each walk makes exactly one memory read: `mem_req_valid` falls in the cycle after the request handshake and stays low until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base (physical byte address) |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| busy | output | 1 | Walk in flight |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 not present, 2 protection |
| paddr | output | 32 | Translated physical address, 0 on fault |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Physical address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry word |

## Verification
A corrupted walk state shows at the ports within one cycle. The read strobe either never appears, repeats after its handshake, or overlaps the completion pulse. A stale latched page number or offset shows only at the next completion, as a wrong entry address or a wrong translated address. A base register that changes while busy stays hidden until the following walk, so each base write is followed by a walk whose entry address is compared.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_RSVD   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    RGT_RDONLY = 2'd0,
    RGT_RDWR   = 2'd1,
    RGT_EXEC   = 2'd2,
    RGT_NONE   = 2'd3
  } rights_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } walk_state_e;

  function automatic logic rights_permit(rights_e r, access_e a);
    logic ok;
    case (r)
      RGT_RDONLY: ok = (a == ACC_READ);
      RGT_RDWR:   ok = (a == ACC_READ) || (a == ACC_WRITE);
      RGT_EXEC:   ok = (a == ACC_READ) || (a == ACC_FETCH);
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int unsigned PA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            walk_busy,
  output logic [PA_W-1:0] base_q
);

  logic            load_en;
  logic [PA_W-1:0] base_d;

  // A write only lands while no walk is using the base.
  always_comb begin
    load_en = wr_en && !walk_busy;
    base_d  = base_q;
    if (load_en) begin
      base_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      base_q <= base_d;
    end
  end

  // R8: the base stays frozen across every cycle of a walk
  assert_base_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |=> (base_q == $past(base_q)));

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned PPN_W = 22
) (
  input  logic [PTE_W-1:0] pte,
  input  access_e          access,
  output fault_e           fault,
  output logic [PPN_W-1:0] ppn
);

  localparam int unsigned PRESENT_BIT = PTE_W - 1;
  localparam int unsigned RGT_HI      = PTE_W - 2;
  localparam int unsigned RGT_LO      = PTE_W - 3;
  localparam int unsigned RSVD_W      = RGT_LO - PPN_W;

  logic    present;
  rights_e rights;
  logic    permit;
  logic    unused_rsvd;

  assign present     = pte[PRESENT_BIT];
  assign rights      = rights_e'(pte[RGT_HI:RGT_LO]);
  assign ppn         = pte[PPN_W-1:0];
  assign unused_rsvd = ^pte[RGT_LO-1 -: RSVD_W];

  always_comb begin
    permit = rights_permit(rights, access);
    if (!present) begin
      fault = FLT_ABSENT;
    end else if (!permit) begin
      fault = FLT_PROT;
    end else begin
      fault = FLT_NONE;
    end
  end

  initial begin
    assert_layout_fits_R7: assert (PPN_W + 3 < PTE_W)
      else $error("entry layout does not fit");
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  input  access_e               req_access,
  input  logic                  mem_req_ready,
  input  logic                  mem_rsp_valid,
  input  fault_e                dec_fault,
  input  logic [PA_W-OFF_W-1:0] dec_ppn,
  output logic                  busy,
  output logic                  mem_req_valid,
  output logic [VA_W-OFF_W-1:0] vpn_q,
  output access_e               access_q,
  output logic                  done,
  output fault_e                fault,
  output logic [PA_W-1:0]       paddr
);

  localparam int unsigned VPN_W = VA_W - OFF_W;

  walk_state_e       state_q, state_d;
  logic              accept;
  logic              rsp_take;
  logic [OFF_W-1:0]  off_q;
  logic              done_q, done_d;
  fault_e            fault_q, fault_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign rsp_take = (state_q == ST_WAIT) && mem_rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d  = rsp_take;
    fault_d = fault_q;
    paddr_d = paddr_q;
    if (rsp_take) begin
      fault_d = dec_fault;
      paddr_d = (dec_fault == FLT_NONE) ? {dec_ppn, off_q} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  // Request fields: captured on acceptance only, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) begin
      vpn_q    <= req_vaddr[VA_W-1:OFF_W];
      off_q    <= req_vaddr[OFF_W-1:0];
      access_q <= req_access;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = done_q;
  assign fault         = fault_q;
  assign paddr         = paddr_q;

  // R2: an unanswered read keeps its request and page index
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(vpn_q)));

  // R9: one handshake ends the read phase
  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  // R4: completion lasts one cycle and never overlaps a walk
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3: a request during a walk does not restart the read
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req_valid) |=> !mem_req_valid);

  // R5: a faulting walk never exposes an address
  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fault != FLT_NONE)) |-> (paddr == '0));

  initial begin
    assert_widths_R2: assert (VPN_W > 0 && OFF_W > 0)
      else $error("bad address split");
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned PTE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [PA_W-1:0]   base_wdata,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_access,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault,
  output logic [PA_W-1:0]   paddr,
  output logic              mem_req_valid,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);

  localparam int unsigned VPN_W       = VA_W - OFF_W;
  localparam int unsigned PPN_W       = PA_W - OFF_W;
  localparam int unsigned ENTRY_SHIFT = $clog2(PTE_W / 8);
  localparam int unsigned IDX_W       = VPN_W + ENTRY_SHIFT;

  logic              rst_sync_n;
  logic [PA_W-1:0]   base_q;
  logic [VPN_W-1:0]  vpn_q;
  access_e           access_q;
  fault_e            dec_fault;
  logic [PPN_W-1:0]  dec_ppn;
  fault_e            fault_e_q;
  logic [IDX_W-1:0]  byte_index;

  ptw_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptw_base_reg #(.PA_W(PA_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (base_we),
    .wr_data   (base_wdata),
    .walk_busy (busy),
    .base_q    (base_q)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_decode (
    .pte    (mem_rsp_data),
    .access (access_q),
    .fault  (dec_fault),
    .ppn    (dec_ppn)
  );

  ptw_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_access    (access_e'(req_access)),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .dec_fault     (dec_fault),
    .dec_ppn       (dec_ppn),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .vpn_q         (vpn_q),
    .access_q      (access_q),
    .done          (done),
    .fault         (fault_e_q),
    .paddr         (paddr)
  );

  // Entry address: base plus page number scaled by the entry size.
  assign byte_index   = {vpn_q, {ENTRY_SHIFT{1'b0}}};
  assign mem_req_addr = base_q + PA_W'(byte_index);
  assign fault        = fault_e_q;

  // R2: the entry address cannot move while the read waits
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

  logic        clk;
  logic        rst_n;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_access;
  logic        busy;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] paddr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] bench_base;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_access(req_access),
    .busy(busy), .done(done), .fault(fault), .paddr(paddr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic [31:0] pte;
    logic [1:0]  stall;
    logic [1:0]  lat;
    logic        poke;
    logic [1:0]  efault;
  } vec_t;

  // access: 0 read, 1 write, 2 fetch, 3 reserved; entry {present, rights, rsvd, ppn}
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    {32'h0000_1234, 2'd0, 32'h8000_0ABC, 2'd0, 2'd0, 1'b0, 2'd0}, // R6 RO read
    {32'h0000_2F00, 2'd1, 32'h8000_0011, 2'd1, 2'd1, 1'b0, 2'd2}, // R6 RO write
    {32'h0012_3456, 2'd2, 32'h8000_0022, 2'd0, 2'd2, 1'b1, 2'd2}, // R6 RO fetch, R3 poke
    {32'h00AB_CDEF, 2'd1, 32'hA03F_FFFF, 2'd2, 2'd0, 1'b0, 2'd0}, // R6 RW write
    {32'h7FFF_0001, 2'd2, 32'hA000_0033, 2'd0, 2'd1, 1'b0, 2'd2}, // R6 RW fetch
    {32'h4000_03FF, 2'd2, 32'hC000_1357, 2'd3, 2'd3, 1'b1, 2'd0}, // R6 EX fetch, R3 poke
    {32'h4000_0400, 2'd1, 32'hC000_1357, 2'd0, 2'd0, 1'b0, 2'd2}, // R6 EX write
    {32'h5555_5555, 2'd0, 32'hC02A_AAAA, 2'd1, 2'd2, 1'b0, 2'd0}, // R6 EX read
    {32'h0000_0000, 2'd0, 32'hE000_0044, 2'd0, 2'd0, 1'b0, 2'd2}, // R6 rights 3
    {32'hFFFF_FFFF, 2'd1, 32'h2000_0055, 2'd0, 2'd1, 1'b0, 2'd1}, // R5 absent RW
    {32'h0BAD_F00D, 2'd0, 32'h3FFF_FFFF, 2'd2, 2'd1, 1'b1, 2'd1}, // R5 absent, R3 poke
    {32'h1357_9BDF, 2'd0, 32'hBFC0_1234, 2'd0, 2'd2, 1'b0, 2'd0}, // R7 reserved bits set
    {32'h2468_ACE0, 2'd3, 32'hA000_0777, 2'd1, 2'd0, 1'b0, 2'd2}  // R6 access 3
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic walk(input vec_t v);
    logic [31:0] exp_addr;
    logic [31:0] exp_pa;
    exp_addr = bench_base + {v.va[31:10], 2'b00};
    exp_pa   = (v.efault == 2'd0) ? {v.pte[21:0], v.va[9:0]} : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_access = v.acc;
    mem_req_ready = (v.stall == 2'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R4 busy after accept", {31'b0, busy}, 32'h1);
    check(mem_req_valid == 1'b1, "R2 read issued", {31'b0, mem_req_valid}, 32'h1);
    check(mem_req_addr == exp_addr, "R2 entry address", mem_req_addr, exp_addr);
    for (int i = 0; i < int'(v.stall); i++) begin
      @(negedge clk);
      check(mem_req_valid && mem_req_addr == exp_addr, "R2 held while stalled",
            mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    check(mem_req_valid == 1'b0, "R9 single read", {31'b0, mem_req_valid}, 32'h0);
    for (int i = 0; i < int'(v.lat); i++) begin
      if (v.poke) begin
        req_valid = 1'b1; req_vaddr = ~v.va; req_access = 2'd0;
        base_we = 1'b1; base_wdata = 32'hDEAD_0000;
      end
      @(negedge clk);
      check(busy && !done, "R4 busy while waiting", {30'b0, busy, done}, 32'h2);
      check(!mem_req_valid, "R3 no read while busy", {31'b0, mem_req_valid}, 32'h0);
    end
    req_valid = 1'b0; base_we = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(done && !busy, "R4 done pulse", {30'b0, done, busy}, 32'h2);
    check(fault == v.efault, "R5/R6 fault code", {30'b0, fault}, {30'b0, v.efault});
    check(paddr == exp_pa, "R7 translated address", paddr, exp_pa);
    @(negedge clk);
    check(!done && !mem_req_valid && !busy, "R4 pulse ends, R3 idle",
          {29'b0, done, mem_req_valid, busy}, 32'h0);
  endtask

  task automatic write_base(input logic [31:0] val);
    @(negedge clk);
    base_we = 1'b1; base_wdata = val;
    @(negedge clk);
    base_we = 1'b0;
    bench_base = val;
  endtask

  initial begin
    rst_n = 1'b0; base_we = 1'b0; base_wdata = '0; req_valid = 1'b0;
    req_vaddr = '0; req_access = '0; mem_req_ready = 1'b1;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; bench_base = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req_valid, "R1 outputs in reset",
          {29'b0, busy, done, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && !mem_req_valid, "R1 outputs after reset",
          {29'b0, busy, done, mem_req_valid}, 32'h0);
    // R1: reset base is 0, seen through the first entry address
    walk('{va:32'h0000_0C00, acc:2'd0, pte:32'h8000_0001, stall:2'd0, lat:2'd0,
           poke:1'b0, efault:2'd0});

    write_base(32'h0010_0000); // R8 idle write
    for (int k = 0; k < NV; k++) begin
      walk(VECS[k]);
    end

    // R8: switching to another table moves the entry address
    write_base(32'hFFFF_FF00);
    walk('{va:32'h0000_0800, acc:2'd1, pte:32'hA000_0101, stall:2'd1, lat:2'd1,
           poke:1'b1, efault:2'd0});
    walk('{va:32'h0001_0000, acc:2'd0, pte:32'h8000_0202, stall:2'd0, lat:2'd0,
           poke:1'b0, efault:2'd0});

    // R1: reset during a walk clears it and the base register
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_4000; req_access = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!busy && !mem_req_valid, "R1 async clear mid-walk",
          {30'b0, busy, mem_req_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    bench_base = 32'h0;
    repeat (4) @(negedge clk);
    walk('{va:32'h0000_4000, acc:2'd0, pte:32'h8000_0303, stall:2'd0, lat:2'd1,
           poke:1'b0, efault:2'd0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule